// File: doc/BRIEF.md
# Last-Arriving Operand Predictor

This block guesses, for an instruction that enters the scheduling window with both source operands still pending, which of the two operands will be produced later. The scheduler uses the guess to watch only one tag with a single comparator. The index into a table of 2-bit saturating counters is the low bits of the instruction address with a global branch-outcome history XORed onto them. The history shifts in each completed branch outcome.

A lookup is answered one cycle later. The answer is a one-bit guess and a copy of the history value that formed the index. When the guess is later checked, the scheduler sends the address, that saved history copy and the true last operand back on the training port. Training therefore updates the same counter the lookup read, even if more branches have completed since the lookup.

Top module: `lastop_predictor`

## Requirements
- R1: After reset every counter holds 01, the history is all zeros and `predValid` is 0, so the first lookup of any address returns `predLeftLast` = 0.
- R2: The table index is the low log2(ENTRIES) bits of the address XORed with the history. The history is zero-extended, so history bit 0 meets address bit 0.
- R3: The prediction is the upper bit of the selected counter. 1 means the left operand is expected last and 0 means the right operand is expected last.
- R4: A lookup that is asserted at a clock edge drives `predValid` high for exactly the next cycle. That cycle carries the guess and `predHist`, the history the lookup used. Both outputs hold their values until the next lookup.
- R5: On `branchValid` the history shifts one place toward its upper bit, and `branchTaken` enters bit 0 (1 = taken). Without `branchValid` the history does not change. A lookup in the same cycle as a branch uses the history from before the shift.
- R6: Training with `trainLeftLast` = 1 increments the counter, which stays at 3 once it reaches 3.
- R7: Training with `trainLeftLast` = 0 decrements the counter, which stays at 0 once it reaches 0.
- R8: Training selects its counter from `trainPc` XOR `trainHist`. The live history does not take part.
- R9: When a lookup and a training pass hit the same counter in the same cycle, the lookup returns the value from before the training.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| lookupValid | input | 1 | Request a guess for `lookupPc` |
| lookupPc | input | PC_W | Address of the instruction to predict |
| predValid | output | 1 | The guess is valid in this cycle |
| predLeftLast | output | 1 | 1 = left operand last, 0 = right operand last |
| predHist | output | HIST_W | History used for the answered lookup |
| branchValid | input | 1 | A branch completed in this cycle |
| branchTaken | input | 1 | Outcome of that branch, 1 = taken |
| trainValid | input | 1 | A checked guess is being reported |
| trainPc | input | PC_W | Address of the checked instruction |
| trainHist | input | HIST_W | History copy returned at lookup |
| trainLeftLast | input | 1 | 1 if the left operand was truly last |

## Verification
Table-driven steps run with the history held at zero. They train single counters up past 3 and down past 0, and then read the counters back. A counter that wraps instead of saturating gives the opposite guess after the follow-up steps. Lookup and training are issued in the same cycle to the same counter, which tells a read-before-write table from a write-through one. Training with a non-zero history snapshot, followed by lookups at the plain and the XORed address, shows which index the training used. Directed branch sequences then build known history values. These sequences tell a correct XOR hash, shift direction and old-history lookup from swapped or late variants, and eight not-taken branches show the oldest bits leaving the history.

// File: rtl/lastop_pkg.sv
package lastop_pkg;

  typedef struct packed {
    logic rdEn;    // read a counter and register the answer
    logic wrEn;    // write a trained counter
    logic histEn;  // shift a branch outcome into the history
  } lastop_strobe_t;

  localparam logic [1:0] CTR_RESET = 2'b01;

  function automatic logic [1:0] satStep(input logic [1:0] ctr, input logic up);
    logic [1:0] res;
    if (up) res = (ctr == 2'b11) ? ctr : ctr + 2'd1;
    else    res = (ctr == 2'b00) ? ctr : ctr - 2'd1;
    return res;
  endfunction

endpackage

// File: rtl/lastop_ctrl.sv
module lastop_ctrl
  import lastop_pkg::*;
(
  input  logic           clk,
  input  logic           rstN,
  input  logic           lookupValid,
  input  logic           branchValid,
  input  logic           trainValid,
  output lastop_strobe_t str,
  output logic           predValid
);

  always_comb begin
    str.rdEn   = lookupValid;
    str.wrEn   = trainValid;
    str.histEn = branchValid;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) predValid <= 1'b0;
    else       predValid <= lookupValid;
  end

  AST_PRED_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    lookupValid |=> predValid);  // R4
  AST_PRED_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !lookupValid |=> !predValid);  // R4

endmodule

// File: rtl/lastop_datapath.sv
module lastop_datapath
  import lastop_pkg::*;
#(
  parameter int PC_W    = 32,
  parameter int HIST_W  = 8,
  parameter int ENTRIES = 2048
) (
  input  logic              clk,
  input  logic              rstN,
  input  lastop_strobe_t    str,
  input  logic [PC_W-1:0]   lookupPc,
  input  logic              branchTaken,
  input  logic [PC_W-1:0]   trainPc,
  input  logic [HIST_W-1:0] trainHist,
  input  logic              trainLeftLast,
  output logic              predLeftLast,
  output logic [HIST_W-1:0] predHist
);

  localparam int IDX_W = $clog2(ENTRIES);

  logic [HIST_W-1:0] histQ;
  logic [1:0]        ctrTable [ENTRIES];
  logic [IDX_W-1:0]  lkIdx;
  logic [IDX_W-1:0]  trIdx;
  logic [1:0]        ctrOld;
  logic [1:0]        ctrNext;

  function automatic logic [IDX_W-1:0] hashIdx(input logic [PC_W-1:0] pc,
                                                input logic [HIST_W-1:0] h);
    return pc[IDX_W-1:0] ^ IDX_W'(h);
  endfunction

  always_comb begin
    lkIdx   = hashIdx(lookupPc, histQ);
    trIdx   = hashIdx(trainPc, trainHist);
    ctrOld  = ctrTable[trIdx];
    ctrNext = satStep(ctrOld, trainLeftLast);
  end

  // counter table: read-before-write on a same-cycle collision
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < ENTRIES; i++) ctrTable[i] <= CTR_RESET;
    end else if (str.wrEn) begin
      ctrTable[trIdx] <= ctrNext;
    end
  end

  // registered answer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      predLeftLast <= 1'b0;
      predHist     <= '0;
    end else if (str.rdEn) begin
      predLeftLast <= ctrTable[lkIdx][1];
      predHist     <= histQ;
    end
  end

  // global outcome history
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           histQ <= '0;
    else if (str.histEn) histQ <= {histQ[HIST_W-2:0], branchTaken};
  end

  AST_HIST_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !str.histEn |=> $stable(histQ));  // R5
  AST_PRED_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !str.rdEn |=> ($stable(predLeftLast) && $stable(predHist)));  // R4
  AST_CTR_UP_DIR: assert property (@(posedge clk) disable iff (!rstN)
    (str.wrEn && trainLeftLast) |-> (ctrNext >= ctrOld));  // R6
  AST_CTR_DOWN_DIR: assert property (@(posedge clk) disable iff (!rstN)
    (str.wrEn && !trainLeftLast) |-> (ctrNext <= ctrOld));  // R7
  AST_CTR_SAT_TOP: assert property (@(posedge clk) disable iff (!rstN)
    (str.wrEn && trainLeftLast && ctrOld == 2'b11) |-> (ctrNext == 2'b11));  // R6
  AST_CTR_SAT_BOTTOM: assert property (@(posedge clk) disable iff (!rstN)
    (str.wrEn && !trainLeftLast && ctrOld == 2'b00) |-> (ctrNext == 2'b00));  // R7

endmodule

// File: rtl/lastop_predictor.sv
module lastop_predictor
  import lastop_pkg::*;
#(
  parameter int PC_W    = 32,
  parameter int HIST_W  = 8,
  parameter int ENTRIES = 2048
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lookupValid,
  input  logic [PC_W-1:0]   lookupPc,
  output logic              predValid,
  output logic              predLeftLast,
  output logic [HIST_W-1:0] predHist,
  input  logic              branchValid,
  input  logic              branchTaken,
  input  logic              trainValid,
  input  logic [PC_W-1:0]   trainPc,
  input  logic [HIST_W-1:0] trainHist,
  input  logic              trainLeftLast
);

  lastop_strobe_t str;

  lastop_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .lookupValid (lookupValid),
    .branchValid (branchValid),
    .trainValid  (trainValid),
    .str         (str),
    .predValid   (predValid)
  );

  lastop_datapath #(
    .PC_W    (PC_W),
    .HIST_W  (HIST_W),
    .ENTRIES (ENTRIES)
  ) u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .str           (str),
    .lookupPc      (lookupPc),
    .branchTaken   (branchTaken),
    .trainPc       (trainPc),
    .trainHist     (trainHist),
    .trainLeftLast (trainLeftLast),
    .predLeftLast  (predLeftLast),
    .predHist      (predHist)
  );

endmodule

// File: tb/lastop_predictor_bench.sv
module lastop_predictor_bench;

  localparam int PC_W = 32;
  localparam int HIST_W = 8;
  localparam int NVEC = 17;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic lookupValid = 1'b0;
  logic [PC_W-1:0] lookupPc = '0;
  logic predValid, predLeftLast;
  logic [HIST_W-1:0] predHist;
  logic branchValid = 1'b0, branchTaken = 1'b0;
  logic trainValid = 1'b0, trainLeftLast = 1'b0;
  logic [PC_W-1:0] trainPc = '0;
  logic [HIST_W-1:0] trainHist = '0;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  lastop_predictor u_lastop_predictor (
    .clk(clk), .rstN(rstN), .lookupValid(lookupValid), .lookupPc(lookupPc),
    .predValid(predValid), .predLeftLast(predLeftLast), .predHist(predHist),
    .branchValid(branchValid), .branchTaken(branchTaken),
    .trainValid(trainValid), .trainPc(trainPc), .trainHist(trainHist),
    .trainLeftLast(trainLeftLast)
  );

  // {lookup, lookupPc[11:0], train, trainPc[11:0], trainHist, trainLeft, expectedGuess}
  localparam logic [35:0] VEC [NVEC] = '{
    {1'b1, 12'h010, 1'b0, 12'h000, 8'h00, 1'b0, 1'b0},  // R1 reset counter 01
    {1'b1, 12'h010, 1'b1, 12'h010, 8'h00, 1'b1, 1'b0},  // R9 old value 01
    {1'b1, 12'h010, 1'b0, 12'h000, 8'h00, 1'b0, 1'b1},  // R6 R3 now 10
    {1'b0, 12'h000, 1'b1, 12'h010, 8'h00, 1'b1, 1'b0},  // -> 11
    {1'b0, 12'h000, 1'b1, 12'h010, 8'h00, 1'b1, 1'b0},  // R6 stays 11
    {1'b0, 12'h000, 1'b1, 12'h010, 8'h00, 1'b0, 1'b0},  // -> 10
    {1'b1, 12'h010, 1'b1, 12'h010, 8'h00, 1'b0, 1'b1},  // R9 reads 10, -> 01
    {1'b1, 12'h010, 1'b0, 12'h000, 8'h00, 1'b0, 1'b0},  // R6 saturation seen
    {1'b0, 12'h000, 1'b1, 12'h020, 8'h00, 1'b0, 1'b0},  // -> 00
    {1'b0, 12'h000, 1'b1, 12'h020, 8'h00, 1'b0, 1'b0},  // R7 stays 00
    {1'b0, 12'h000, 1'b1, 12'h020, 8'h00, 1'b1, 1'b0},  // -> 01
    {1'b0, 12'h000, 1'b1, 12'h020, 8'h00, 1'b1, 1'b0},  // -> 10
    {1'b1, 12'h020, 1'b0, 12'h000, 8'h00, 1'b0, 1'b1},  // R7 saturation seen
    {1'b0, 12'h000, 1'b1, 12'h030, 8'h05, 1'b1, 1'b0},  // idx 035 -> 10
    {1'b0, 12'h000, 1'b1, 12'h030, 8'h05, 1'b1, 1'b0},  // idx 035 -> 11
    {1'b1, 12'h035, 1'b0, 12'h000, 8'h00, 1'b0, 1'b1},  // R8 hashed index trained
    {1'b1, 12'h030, 1'b0, 12'h000, 8'h00, 1'b0, 1'b0}   // R8 plain index untouched
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idleInputs();
    lookupValid = 1'b0; trainValid = 1'b0; branchValid = 1'b0;
  endtask

  task automatic branch(input logic taken);
    branchValid = 1'b1; branchTaken = taken;
    @(negedge clk);
    idleInputs();
  endtask

  task automatic lookupChk(input string req, input logic [11:0] pc,
                           input logic expPred, input logic [7:0] expHist);
    lookupValid = 1'b1; lookupPc = PC_W'(pc);
    @(negedge clk);
    idleInputs();
    chk(req, 32'(predValid), 32'd1);
    chk(req, 32'(predLeftLast), 32'(expPred));
    chk(req, 32'(predHist), 32'(expHist));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 predValid in reset", 32'(predValid), 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 predValid after reset", 32'(predValid), 32'd0);
    chk("R1 predHist after reset", 32'(predHist), 32'd0);

    for (int i = 0; i < NVEC; i++) begin
      lookupValid   = VEC[i][35];
      lookupPc      = PC_W'(VEC[i][34:23]);
      trainValid    = VEC[i][22];
      trainPc       = PC_W'(VEC[i][21:10]);
      trainHist     = VEC[i][9:2];
      trainLeftLast = VEC[i][1];
      @(negedge clk);
      chk("R4 predValid follows lookup", 32'(predValid), 32'(VEC[i][35]));
      if (VEC[i][35]) begin
        chk("R3 R6 R7 R8 R9 guess", 32'(predLeftLast), 32'(VEC[i][0]));
        chk("R4 predHist zero history", 32'(predHist), 32'd0);
      end
    end
    idleInputs();

    // history 1,0,1 -> 0x05 ; index 030^05 = 035 holds 11
    branch(1'b1); branch(1'b0); branch(1'b1);
    lookupChk("R2 R5 xor index with history 05", 12'h030, 1'b1, 8'h05);
    // idle cycle: outputs hold, predValid low
    @(negedge clk);
    chk("R4 predValid drops", 32'(predValid), 32'd0);
    chk("R4 guess held", 32'(predLeftLast), 32'd1);
    chk("R4 hist held", 32'(predHist), 32'h05);

    // branch and lookup together: lookup sees 05
    branchValid = 1'b1; branchTaken = 1'b1;
    lookupChk("R5 same-cycle lookup uses old history", 12'h030, 1'b1, 8'h05);
    // history now 0x0B ; 03E ^ 0B = 035
    lookupChk("R2 R5 shifted history 0B", 12'h03E, 1'b1, 8'h0B);
    lookupChk("R2 untrained index under history 0B", 12'h035, 1'b0, 8'h0B);

    // eight not-taken branches flush the history
    for (int k = 0; k < 8; k++) branch(1'b0);
    lookupChk("R5 history shifted out", 12'h035, 1'b1, 8'h00);
    lookupChk("R1 untouched counter", 12'h100, 1'b0, 8'h00);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule